// File: doc/BRIEF.md
# Embedded-Clock Word Receiver

This block sits behind the serial receiver of a 14:1 link. It takes one data bit per strobe of `bit_vld`, hunts for the start marker that the transmitter places in front of each word, gathers the twelve data bits that follow, and presents them on a parallel bus. It also rebuilds the word clock for the parallel sink. Everything runs from one system clock; the bit-clock recovery and the line receivers are outside the block.

A frame on the line has three parts: a start marker of one `1` bit followed by one `0` bit, then twelve data bits. Between frames the line carries zero bits. These are idle time, or the two padding zeros that the overclocked transmitter cadence inserts every third word (frame lengths 14, 14, 16). The rebuilt word clock falls a fixed number of bit times after each new word and stays low for a fixed number of bit times. The high phase absorbs whatever idle bits separate the frames, so the clock period follows the transmitter's word rate.

Two inputs control the block. Clearing `rx_en` models a direction change away from receive. It drops any half-received word and leaves the bus at the last good word. `pwr_dn` clears the whole block and drives every output low.

Top module: `ecw_rx`

## Requirements
- R1: While `rst_n` is low or `pwr_dn` is high at a clock edge, `word_out` is 0, `word_clk` is 0 and `frame_err` is 0, and any partial frame is dropped. `word_clk` is 1 in the first cycle after both are released.
- R2: Only bits sampled with `bit_vld`=1 are used. A frame is the bit 1, then the bit 0, then twelve data bits least significant bit first. All-zero and all-one data words decode like any other word.
- R3: `word_out` takes the received word at the clock edge that samples the last data bit. Apart from R1 it changes at no other time.
- R4: Any number of zero bits between frames leaves `word_out` unchanged and causes no fall of `word_clk`. This includes the two padding zeros.
- R5: `word_clk` falls at the 8th bit strobe after the strobe that completed a word.
- R6: Once low, `word_clk` stays low for exactly 13 bit strobes and rises at the 13th. It then stays high until the next fall set by R5.
- R7: Back-to-back 14-bit frames give a word clock period of 14 strobes with a high phase of 1 strobe. A 16-bit frame stretches the high phase to 3 strobes.
- R8: A `1` bit where the `0` half of the marker is expected sets `frame_err`, and the hunt for a new marker starts with the next bit.
- R9: `rx_en`=0 drops a partial frame and ignores the bits received meanwhile. `word_out` keeps the last word, and after `rx_en` returns a complete new frame is needed.
- R10: `frame_err` stays set until R1 clears it.
- R11: `word_out` never changes in the clock edge at which `word_clk` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Synchronous power-down: clears state, outputs low |
| rx_en | input | 1 | Receive direction enable; low drops a partial frame |
| bit_vld | input | 1 | One-cycle strobe marking a valid serial bit |
| bit_in | input | 1 | Serial data bit, sampled when `bit_vld` is high |
| word_out | output | 12 | Last received data word |
| word_clk | output | 1 | Regenerated word clock |
| frame_err | output | 1 | Sticky marker error flag |

## Verification
A single frame with an irregular data pattern, surrounded by idle zeros, pins down the bit order and the strobe numbers of the update, the fall and the rise. A train of 14, 14 and 16-bit frames separates a high phase that stretches correctly from a fixed-period clock or a fall counter that drifts. All-zero and all-one words probe the marker hunt at its edges. A doubled `1` marker, a receive disable in the middle of a frame, and a power-down in the middle of a frame each show that a broken frame never reaches the bus. Long idle runs show that zeros alone never move the word clock.

// File: rtl/ecw_pkg.sv
package ecw_pkg;

    // Frame hunter states
    typedef enum logic [1:0] {
        D_HUNT = 2'd0,   // waiting for the 1 half of the marker
        D_MARK = 2'd1,   // got 1, expecting the 0 half
        D_DATA = 2'd2    // collecting data bits
    } des_st_t;

    // Word clock states
    typedef enum logic {
        WC_HIGH = 1'b0,
        WC_LOW  = 1'b1
    } wc_st_t;

endpackage

// File: rtl/ecw_deframer.sv
module ecw_deframer
    import ecw_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              rx_en,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word_q,
    output logic              word_done,
    output logic              err_q
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    des_st_t           state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              err_set;
    logic              take;

    assign take = bit_vld && rx_en;

    // Next state and events
    always_comb begin
        state_d   = state_q;
        err_set   = 1'b0;
        word_done = 1'b0;
        if (!rx_en) begin
            state_d = D_HUNT;
        end else if (bit_vld) begin
            unique case (state_q)
                D_HUNT: if (bit_in) state_d = D_MARK;
                D_MARK: begin
                    if (bit_in) begin
                        err_set = 1'b1;
                        state_d = D_HUNT;
                    end else begin
                        state_d = D_DATA;
                    end
                end
                D_DATA: begin
                    if (cnt_q == LAST_BIT) begin
                        word_done = 1'b1;
                        state_d   = D_HUNT;
                    end
                end
                default: state_d = D_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= D_HUNT;
        else if (pwr_dn) state_q <= D_HUNT;
        else             state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            word_q  <= '0;
            err_q   <= 1'b0;
        end else if (pwr_dn) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            word_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            if (take && state_q == D_MARK) cnt_q <= '0;
            else if (take && state_q == D_DATA) cnt_q <= cnt_q + 1'b1;
            if (take && state_q == D_DATA)
                shreg_q <= {bit_in, shreg_q[DATA_W-1:1]};
            if (word_done)
                word_q <= {bit_in, shreg_q[DATA_W-1:1]};
            if (err_set)
                err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ecw_wclk_gen.sv
module ecw_wclk_gen
    import ecw_pkg::*;
#(
    parameter int FALL_DLY = 8,
    parameter int LOW_BITS = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn,
    input  logic bit_vld,
    input  logic word_done,
    output logic wclk_q
);

    localparam int ARM_W = $clog2(FALL_DLY + 1);
    localparam int LOW_W = $clog2(LOW_BITS + 1);
    localparam logic [ARM_W-1:0] ARM_LOAD = ARM_W'(FALL_DLY);
    localparam logic [LOW_W-1:0] LOW_LOAD = LOW_W'(LOW_BITS);

    wc_st_t           state_q, state_d;
    logic [ARM_W-1:0] arm_q, arm_d;
    logic [LOW_W-1:0] low_q, low_d;
    logic             fall_now;

    assign fall_now = bit_vld && (arm_q == ARM_W'(1));

    always_comb begin
        state_d = state_q;
        low_d   = low_q;
        arm_d   = arm_q;
        if (word_done)
            arm_d = ARM_LOAD;
        else if (bit_vld && arm_q != '0)
            arm_d = arm_q - 1'b1;
        unique case (state_q)
            WC_HIGH: begin
                if (fall_now) begin
                    state_d = WC_LOW;
                    low_d   = LOW_LOAD;
                end
            end
            WC_LOW: begin
                if (bit_vld) begin
                    low_d = low_q - 1'b1;
                    if (low_q == LOW_W'(1)) state_d = WC_HIGH;
                end
            end
            default: state_d = WC_HIGH;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WC_HIGH;
            arm_q   <= '0;
            low_q   <= '0;
        end else if (pwr_dn) begin
            state_q <= WC_HIGH;
            arm_q   <= '0;
            low_q   <= '0;
        end else begin
            state_q <= state_d;
            arm_q   <= arm_d;
            low_q   <= low_d;
        end
    end

    // Output register: low in reset and power-down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wclk_q <= 1'b0;
        else if (pwr_dn) wclk_q <= 1'b0;
        else             wclk_q <= (state_d == WC_HIGH);
    end

endmodule

// File: rtl/ecw_rx.sv
module ecw_rx #(
    parameter int DATA_W   = 12,
    parameter int FALL_DLY = 8,
    parameter int LOW_BITS = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              rx_en,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word_out,
    output logic              word_clk,
    output logic              frame_err
);

    logic word_done;

    ecw_deframer #(.DATA_W(DATA_W)) i_deframer (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_dn    (pwr_dn),
        .rx_en     (rx_en),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .word_q    (word_out),
        .word_done (word_done),
        .err_q     (frame_err)
    );

    ecw_wclk_gen #(.FALL_DLY(FALL_DLY), .LOW_BITS(LOW_BITS)) i_wclk_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_dn    (pwr_dn),
        .bit_vld   (bit_vld),
        .word_done (word_done),
        .wclk_q    (word_clk)
    );

endmodule

// File: rtl/ecw_rx_chk.sv
module ecw_rx_chk #(
    parameter int DATA_W   = 12,
    parameter int FALL_DLY = 8,
    parameter int LOW_BITS = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_dn,
    input logic              rx_en,
    input logic              bit_vld,
    input logic [DATA_W-1:0] word_out,
    input logic              word_clk,
    input logic              frame_err,
    input logic              word_done
);

    localparam int LC_W = $clog2(LOW_BITS + 2);
    localparam int SD_W = $clog2(FALL_DLY + 2);
    localparam logic [LC_W-1:0] LC_MAX = {LC_W{1'b1}};
    localparam logic [SD_W-1:0] SD_MAX = {SD_W{1'b1}};

    logic [LC_W-1:0] low_cnt;
    logic            seen_hi;
    logic [SD_W-1:0] since_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || pwr_dn) begin
            low_cnt    <= '0;
            seen_hi    <= 1'b0;
            since_done <= SD_MAX;
        end else begin
            if (word_clk) begin
                low_cnt <= '0;
                seen_hi <= 1'b1;
            end else if (seen_hi && bit_vld && low_cnt != LC_MAX) begin
                low_cnt <= low_cnt + 1'b1;
            end
            if (word_done) since_done <= '0;
            else if (bit_vld && since_done != SD_MAX) since_done <= since_done + 1'b1;
        end
    end

    AST_PD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (word_out == '0 && !word_clk && !frame_err)); // R1

    AST_WORD_ONLY_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
        !$stable(word_out) |-> ($past(pwr_dn) || $past(bit_vld && rx_en))); // R3

    AST_FALL_DELAY: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
        $fell(word_clk) |-> since_done == SD_W'(FALL_DLY)); // R5

    AST_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
        ($rose(word_clk) && seen_hi) |-> low_cnt == LC_W'(LOW_BITS)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !pwr_dn) |=> frame_err); // R10

    AST_STABLE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
        $fell(word_clk) |-> $stable(word_out)); // R11

endmodule

bind ecw_rx ecw_rx_chk #(
    .DATA_W(DATA_W), .FALL_DLY(FALL_DLY), .LOW_BITS(LOW_BITS)
) i_ecw_rx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn    (pwr_dn),
    .rx_en     (rx_en),
    .bit_vld   (bit_vld),
    .word_out  (word_out),
    .word_clk  (word_clk),
    .frame_err (frame_err),
    .word_done (word_done)
);

// File: tb/test_ecw_rx.sv
`timescale 1ns/1ps
module test_ecw_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        rx_en = 1'b1;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic [11:0] word_out;
    logic        word_clk;
    logic        frame_err;

    int errors = 0;
    int checks = 0;
    int strobe_n = 0;
    int last_upd = -1;
    int nf = 0;
    int nr = 0;
    int fall_log [0:63];
    int rise_log [0:63];
    logic        prev_wclk = 1'b0;
    logic [11:0] prev_word = '0;

    always #10 clk = ~clk;

    ecw_rx i_ecw_rx (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .rx_en(rx_en),
        .bit_vld(bit_vld), .bit_in(bit_in),
        .word_out(word_out), .word_clk(word_clk), .frame_err(frame_err)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic sample();
        if (prev_wclk && !word_clk && nf < 64) begin fall_log[nf] = strobe_n; nf++; end
        if (!prev_wclk && word_clk && nr < 64) begin rise_log[nr] = strobe_n; nr++; end
        if (word_out != prev_word) last_upd = strobe_n;
        prev_wclk = word_clk;
        prev_word = word_out;
    endtask

    // Called at a falling edge; returns at a falling edge, one strobe per 3 cycles
    task automatic send_bit(input logic b);
        bit_in  = b;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'b0;
        strobe_n++;
        sample();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic send_frame(input logic [11:0] w);
        send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 12; i++) send_bit(w[i]);
    endtask

    task automatic t_reset();
        chk(word_out == 12'h000, "R1 reset word", int'(word_out), 0);
        chk(word_clk == 1'b0, "R1 reset wclk", int'(word_clk), 0);
        chk(frame_err == 1'b0, "R1 reset err", int'(frame_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word_clk == 1'b1, "R1 wclk high after reset", int'(word_clk), 1);
        prev_wclk = word_clk;
        prev_word = word_out;
    endtask

    task automatic t_single();
        int s;
        idle(3);
        s = strobe_n + 1;
        send_frame(12'hA5C);
        chk(word_out == 12'hA5C, "R2 word value LSB first", int'(word_out), 'hA5C);
        chk(last_upd == s + 13, "R3 update strobe", last_upd, s + 13);
        idle(25);
        chk(nf > 0 && fall_log[nf-1] == s + 21, "R5 fall 8 strobes after word", fall_log[nf-1], s + 21);
        chk(nr > 0 && rise_log[nr-1] == s + 34, "R6 low for 13 strobes", rise_log[nr-1], s + 34);
        chk(word_clk == 1'b1, "R6 high until next word", int'(word_clk), 1);
    endtask

    task automatic t_cadence();
        int s, f0, r0;
        s = strobe_n + 1;
        f0 = nf;
        r0 = nr;
        send_frame(12'h123);
        send_frame(12'h456);
        send_frame(12'h789);
        idle(2);
        send_frame(12'hBCD);
        idle(25);
        chk(nf - f0 == 4, "R7 one fall per word", nf - f0, 4);
        chk(fall_log[f0+1] - fall_log[f0] == 14, "R7 period 14", fall_log[f0+1] - fall_log[f0], 14);
        chk(fall_log[f0+2] - fall_log[f0+1] == 14, "R7 period 14 second", fall_log[f0+2] - fall_log[f0+1], 14);
        chk(fall_log[f0+3] - fall_log[f0+2] == 16, "R7 period 16 with padding", fall_log[f0+3] - fall_log[f0+2], 16);
        chk(fall_log[f0+1] - rise_log[r0] == 1, "R7 high 1 strobe", fall_log[f0+1] - rise_log[r0], 1);
        chk(fall_log[f0+3] - rise_log[r0+2] == 3, "R7 high 3 strobes", fall_log[f0+3] - rise_log[r0+2], 3);
        chk(fall_log[f0] == s + 21, "R5 fall in train", fall_log[f0], s + 21);
        chk(word_out == 12'hBCD, "R4 padding tolerated", int'(word_out), 'hBCD);
    endtask

    task automatic t_idle();
        int f0;
        logic [11:0] w;
        f0 = nf;
        w = word_out;
        idle(40);
        chk(nf == f0, "R4 no fall on idle", nf - f0, 0);
        chk(word_out == w, "R4 word held on idle", int'(word_out), int'(w));
    endtask

    task automatic t_error();
        logic [11:0] w;
        w = word_out;
        send_bit(1'b1);
        send_bit(1'b1);
        chk(frame_err == 1'b1, "R8 doubled marker flags error", int'(frame_err), 1);
        chk(word_out == w, "R8 no word from bad marker", int'(word_out), int'(w));
        idle(2);
        send_frame(12'h3C6);
        chk(word_out == 12'h3C6, "R8 hunt resumes", int'(word_out), 'h3C6);
        idle(25);
        chk(frame_err == 1'b1, "R10 error sticky", int'(frame_err), 1);
    endtask

    task automatic t_disable();
        int f0;
        logic [11:0] w;
        w = word_out;
        f0 = nf;
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        rx_en = 1'b0;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        rx_en = 1'b1;
        idle(5);
        idle(20);
        chk(word_out == w, "R9 partial frame dropped", int'(word_out), int'(w));
        chk(nf == f0, "R9 no word clock for dropped frame", nf - f0, 0);
        send_frame(12'h000);
        chk(word_out == 12'h000, "R2 all-zero word", int'(word_out), 0);
        idle(3);
        send_frame(12'hFFF);
        chk(word_out == 12'hFFF, "R2 all-one word", int'(word_out), 'hFFF);
        idle(25);
    endtask

    task automatic t_pwrdn();
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        pwr_dn = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(word_out == 12'h000, "R1 power-down word low", int'(word_out), 0);
        chk(word_clk == 1'b0, "R1 power-down wclk low", int'(word_clk), 0);
        chk(frame_err == 1'b0, "R10 error cleared by power-down", int'(frame_err), 0);
        pwr_dn = 1'b0;
        @(negedge clk);
        chk(word_clk == 1'b1, "R1 wclk high after power-down", int'(word_clk), 1);
        prev_wclk = word_clk;
        prev_word = word_out;
        idle(12);
        chk(word_out == 12'h000, "R1 partial frame lost", int'(word_out), 0);
        send_frame(12'h5A1);
        chk(word_out == 12'h5A1, "R3 recovers after power-down", int'(word_out), 'h5A1);
        idle(25);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_single();
        t_cadence();
        t_idle();
        t_error();
        t_disable();
        t_pwrdn();
        summary();
        $finish;
    end

endmodule